// File: doc/BRIEF.md
# Escalating Stage Watchdog

This block is a per-core watchdog timer that climbs a ladder of warnings when software stops servicing it. The ladder has three steps. The first timeout raises an interrupt. A second timeout, with no service in between, raises a non-maskable interrupt. A third timeout requests a chip soft reset. One programmed length sets the duration of every step. A mode field sets how far up the ladder the watchdog may climb.

The length field forms the upper bits of a wider down-counter. A fixed prescaler clocks that counter once every 2^PRE_W cycles, so one period lasts LEN × 2^(FRAC_W+PRE_W) clocks. With the default parameters this is LEN × 65536 clocks. A poke reloads the counter, restarts the prescaler and returns the ladder to idle. A configuration write does the same and also latches the new length and mode. The current stage can always be read. A handler can test bit 1 of the stage to tell a watchdog NMI apart from other NMI sources.

Top module: `wdt_escalator`

## Requirements
- R1: After reset, mode is 0 (disabled), the stage reads 0, and irq_o, nmi_o and srst_o are low.
- R2: With mode nonzero and LEN ≥ 1, irq_o rises and the stage becomes 1 exactly LEN × 2^(FRAC_W+PRE_W) clock edges after the edge that captured the configuration write or poke.
- R3: With no service and mode ≥ 2, nmi_o rises and the stage becomes 2 exactly two periods after that edge. The stage only ever moves up by one, or back to 0.
- R4: With no service and mode 3, the stage becomes 3 exactly three periods after that edge. srst_o is high for exactly that one cycle.
- R5: The mode caps the ladder: mode 1 gives stage 1 at most, mode 2 gives stage 2 at most, and mode 3 gives stage 3. Once at its cap the stage stays there.
- R6: Mode 0 disables the watchdog. A write of all zeros (length 0, mode 0) drops every output, returns the stage to 0, and no stage is ever reached afterwards.
- R7: A poke returns the stage to 0 and drops irq_o and nmi_o at the capturing edge. The next interrupt comes one full period after that edge.
- R8: A configuration write reloads the counter and returns the stage to 0 at its capturing edge, whatever the previous stage was.
- R9: The stage is encoded as 0 idle, 1 interrupt, 2 NMI and 3 reset. Bit 1 of the stage is high exactly when nmi_o is high, and nmi_o never rises without irq_o.
- R10: irq_o and nmi_o are levels. Once raised, they stay high until a poke or a configuration write.
- R11: When a configuration write and a poke arrive in the same cycle, the write's length and mode take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | LEN_W | Period length; upper bits of the counter reload |
| cfg_mode | input | 2 | Highest stage allowed; 0 disables |
| poke | input | 1 | Service strobe |
| irq_o | output | 1 | Interrupt level (stage ≥ 1) |
| nmi_o | output | 1 | Non-maskable interrupt level (stage ≥ 2) |
| srst_o | output | 1 | One-cycle soft-reset request |
| stage_o | output | 2 | Current ladder stage |

## Verification
The assertions assume that the poke and write strobes are synchronous single-cycle pulses. They also assume that the latched mode is the only limit on the ladder, so they compare the stage against that register and not against the input field. The stimulus drives every strobe on the falling edge for exactly one cycle. It sweeps every nonzero length of a reduced build across all three active modes, which keeps each run short enough to watch all three periods elapse. Pokes, zero writes and combined write-plus-poke cycles are placed in the middle of periods and stages, always as clean pulses.

// File: rtl/wdt_pkg.sv
// Shared types for the escalating watchdog.
// Assumes a two-bit stage whose numeric value orders the ladder.
package wdt_pkg;

    typedef enum logic [1:0] {
        STG_IDLE = 2'd0,
        STG_IRQ  = 2'd1,
        STG_NMI  = 2'd2,
        STG_RST  = 2'd3
    } stage_e;

    // Highest stage a given mode value may reach.
    function automatic stage_e stage_cap(input logic [1:0] mode);
        case (mode)
            2'd1:    return STG_IRQ;
            2'd2:    return STG_NMI;
            2'd3:    return STG_RST;
            default: return STG_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
// Free-running divider that emits one tick every 2**PRE_W cycles.
// Assumes restart zeroes the phase so a period starts exactly at a service edge.
module wdt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    logic [PRE_W-1:0] div_q;

    // Advance the phase while running; hold it at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (restart || !run)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    // A tick marks the last cycle of each divided interval.
    always_comb tick = run && !restart && (div_q == {PRE_W{1'b1}});

endmodule

// File: rtl/wdt_countdown.sv
// Period counter: reloads with {len, zeros} and flags expiry on the tick that ends a period.
// Assumes len >= 1 for meaningful periods; len 0 expires on every tick.
module wdt_countdown #(
    parameter int LEN_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             tick,
    output logic             expire
);
    localparam int CNT_W = LEN_W + FRAC_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;
    logic             last;

    // Reload value and end-of-period detect.
    always_comb begin
        reload = {len, {FRAC_W{1'b0}}};
        last   = (cnt_q <= CNT_W'(1));
        expire = tick && !load && last;
    end

    // Count down on ticks; reload on service or at period end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= reload;
        else if (tick)
            cnt_q <= last ? reload : cnt_q - 1'b1;
    end

endmodule

// File: rtl/wdt_ladder.sv
// Stage machine: climbs one step per expiry up to the cap, pulses reset on entering the top.
// Assumes clear has priority over expiry in the same cycle.
module wdt_ladder
    import wdt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear,
    input  logic   expire,
    input  stage_e cap,
    output stage_e stage,
    output logic   srst
);
    // Step the ladder and produce the one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= STG_IDLE;
            srst  <= 1'b0;
        end else begin
            srst <= 1'b0;
            if (clear) begin
                stage <= STG_IDLE;
            end else if (expire && (stage < cap)) begin
                stage <= stage_e'(stage + 2'd1);
                srst  <= (stage == STG_NMI);
            end
        end
    end

endmodule

// File: rtl/wdt_escalator.sv
// Top of the escalating watchdog: configuration latch, prescaler, counter and ladder.
// Assumes cfg_we and poke are single-cycle synchronous strobes; cfg_we wins over poke.
module wdt_escalator
    import wdt_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int FRAC_W = 8,
    parameter int PRE_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [1:0]       cfg_mode,
    input  logic             poke,
    output logic             irq_o,
    output logic             nmi_o,
    output logic             srst_o,
    output logic [1:0]       stage_o
);
    logic [LEN_W-1:0] len_q;
    logic [1:0]       mode_q;
    logic             restart;
    logic             run;
    logic             tick;
    logic             expire;
    stage_e           stage;

    // Latch the configuration on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            mode_q <= 2'd0;
        end else if (cfg_we) begin
            len_q  <= cfg_len;
            mode_q <= cfg_mode;
        end
    end

    // Service events and enable.
    always_comb begin
        restart = cfg_we || poke;
        run     = (mode_q != 2'd0);
    end

    wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .tick    (tick)
    );

    wdt_countdown #(.LEN_W(LEN_W), .FRAC_W(FRAC_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (restart),
        .len    (cfg_we ? cfg_len : len_q),
        .tick   (tick),
        .expire (expire)
    );

    wdt_ladder u_lad (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart),
        .expire (expire),
        .cap    (stage_cap(mode_q)),
        .stage  (stage),
        .srst   (srst_o)
    );

    // Level outputs decoded from the stage.
    always_comb begin
        stage_o = stage;
        irq_o   = (stage != STG_IDLE);
        nmi_o   = stage[1];
    end

endmodule

// File: rtl/wdt_escalator_chk.sv
// Property checker for the escalating watchdog, bound to every instance of the top.
// Assumes strobes are synchronous to clk.
module wdt_escalator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic       poke,
    input logic [1:0] mode_q,
    input logic [1:0] stage_o,
    input logic       irq_o,
    input logic       nmi_o,
    input logic       srst_o
);
    // R4
    srst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |=> !srst_o);

    // R4
    srst_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |-> (stage_o == 2'd3 && $past(stage_o) == 2'd2));

    // R5
    stage_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_o <= mode_q);

    // R7
    poke_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(poke) |-> (stage_o == 2'd0 && !irq_o && !nmi_o));

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !poke && !cfg_we) |=> irq_o);

    // R9
    nmi_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> irq_o);

    // R3
    stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_o != $past(stage_o)) |-> (stage_o == 2'd0 || stage_o == $past(stage_o) + 2'd1));

endmodule

bind wdt_escalator wdt_escalator_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .poke    (poke),
    .mode_q  (mode_q),
    .stage_o (stage_o),
    .irq_o   (irq_o),
    .nmi_o   (nmi_o),
    .srst_o  (srst_o)
);

// File: tb/tb_wdt_escalator.sv
// Bench: sweeps every length and active mode of a reduced build, plus service corner cases.
module tb_wdt_escalator;
    localparam int LEN_W  = 4;
    localparam int FRAC_W = 2;
    localparam int PRE_W  = 2;
    localparam int UNIT   = 1 << (FRAC_W + PRE_W);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic [1:0]       cfg_mode = 2'd0;
    logic             poke = 1'b0;
    logic             irq_o, nmi_o, srst_o;
    logic [1:0]       stage_o;

    int checks = 0;
    int failures = 0;

    wdt_escalator #(.LEN_W(LEN_W), .FRAC_W(FRAC_W), .PRE_W(PRE_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
        .cfg_mode(cfg_mode), .poke(poke), .irq_o(irq_o), .nmi_o(nmi_o),
        .srst_o(srst_o), .stage_o(stage_o)
    );

    always #5 clk = ~clk;

    // Record one check and report on mismatch.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one strobe cycle; returns at the negedge just after the capturing edge.
    task automatic strobe(input bit we, input int len, input int mode, input bit pk);
        @(negedge clk);
        cfg_we   = we;
        cfg_len  = LEN_W'(len);
        cfg_mode = 2'(mode);
        poke     = pk;
        @(negedge clk);
        cfg_we = 1'b0;
        poke   = 1'b0;
    endtask

    // Watch for n cycles after a strobe; record first cycle of each stage and reset pulses.
    task automatic watch(input int n, output int first1, output int first2,
                         output int first3, output int pulses, output int maxstg,
                         output int bad);
        first1 = -1; first2 = -1; first3 = -1; pulses = 0; maxstg = 0; bad = 0;
        for (int c = 1; c <= n; c++) begin
            @(negedge clk);
            if (stage_o >= 1 && first1 < 0) first1 = c;
            if (stage_o >= 2 && first2 < 0) first2 = c;
            if (stage_o == 3 && first3 < 0) first3 = c;
            if (int'(stage_o) > maxstg) maxstg = int'(stage_o);
            if (srst_o) pulses++;
            if (nmi_o != stage_o[1] || (nmi_o && !irq_o) || irq_o != (stage_o != 0)) bad++;
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int f1, f2, f3, np, mx, bad, per;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(stage_o == 0 && !irq_o && !nmi_o && !srst_o, "R1 reset outputs", int'(stage_o), 0);
        watch(200, f1, f2, f3, np, mx, bad);
        chk(mx == 0 && np == 0, "R1 disabled after reset", mx, 0);

        // Sweep every length and active mode.
        for (int len = 1; len < (1 << LEN_W); len++) begin
            for (int mode = 1; mode <= 3; mode++) begin
                per = len * UNIT;
                strobe(1'b1, len, mode, 1'b0);
                // R8 write clears the stage at its edge
                chk(stage_o == 0 && !irq_o, "R8 write clears stage", int'(stage_o), 0);
                watch((mode + 2) * per, f1, f2, f3, np, mx, bad);
                chk(f1 == per, "R2 first period", f1, per);
                chk(f2 == ((mode >= 2) ? 2 * per : -1), "R3 second period", f2, (mode >= 2) ? 2 * per : -1);
                chk(f3 == ((mode == 3) ? 3 * per : -1), "R4 third period", f3, (mode == 3) ? 3 * per : -1);
                chk(np == ((mode == 3) ? 1 : 0), "R4 single reset pulse", np, (mode == 3) ? 1 : 0);
                chk(mx == mode, "R5 stage capped by mode", mx, mode);
                chk(int'(stage_o) == mode, "R5 stays at cap", int'(stage_o), mode);
                chk(bad == 0, "R9 stage encoding vs outputs", bad, 0);
            end
        end

        // R10 levels hold through the NMI stage, then R7 poke clears.
        strobe(1'b1, 2, 2, 1'b0);
        per = 2 * UNIT;
        watch(2 * per, f1, f2, f3, np, mx, bad);
        chk(irq_o && nmi_o && stage_o == 2, "R10 nmi level reached", int'(stage_o), 2);
        watch(per, f1, f2, f3, np, mx, bad);
        chk(f2 == 1 && irq_o && nmi_o, "R10 levels held", int'(nmi_o), 1);
        strobe(1'b0, 0, 0, 1'b1);
        chk(stage_o == 0 && !irq_o && !nmi_o, "R7 poke clears", int'(stage_o), 0);
        watch(3 * per, f1, f2, f3, np, mx, bad);
        chk(f1 == per && f2 == 2 * per, "R7 full period after poke", f1, per);

        // R7 poke in mid-period delays the interrupt.
        strobe(1'b1, 3, 3, 1'b0);
        per = 3 * UNIT;
        watch(per / 2 + 1, f1, f2, f3, np, mx, bad);
        chk(f1 == -1, "R7 no irq before poke", f1, -1);
        strobe(1'b0, 0, 0, 1'b1);
        watch(per, f1, f2, f3, np, mx, bad);
        chk(f1 == per, "R7 mid-period poke restarts", f1, per);

        // R6 mode 0 never escalates.
        strobe(1'b1, 5, 0, 1'b0);
        watch(20 * UNIT, f1, f2, f3, np, mx, bad);
        chk(mx == 0 && np == 0 && !irq_o, "R6 mode zero idle", mx, 0);

        // R6 all-zero write while in NMI stage drops everything.
        strobe(1'b1, 1, 3, 1'b0);
        watch(2 * UNIT, f1, f2, f3, np, mx, bad);
        chk(stage_o == 2, "R6 setup nmi stage", int'(stage_o), 2);
        strobe(1'b1, 0, 0, 1'b0);
        chk(stage_o == 0 && !irq_o && !nmi_o && !srst_o, "R6 zero write clears", int'(stage_o), 0);
        watch(20 * UNIT, f1, f2, f3, np, mx, bad);
        chk(mx == 0 && np == 0, "R6 stays disabled", mx, 0);

        // R11 write and poke together: write values win.
        strobe(1'b1, 1, 3, 1'b0);
        watch(UNIT / 2, f1, f2, f3, np, mx, bad);
        strobe(1'b1, 2, 1, 1'b1);
        watch(4 * 2 * UNIT, f1, f2, f3, np, mx, bad);
        chk(f1 == 2 * UNIT, "R11 new length applied", f1, 2 * UNIT);
        chk(mx == 1, "R11 new mode applied", mx, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule